// File: doc/BRIEF.md
# Prescaled Interval Timer Controller

An 8-bit interval timer that advances on count pulses taken from a free-running 10-bit prescaler. A mode register chooses one of four power-of-two divide ratios, gates counting with a run bit, and accepts a one-shot start command. A modulo register holds the compare value. When the counter sits at that value and the next count pulse arrives, the counter returns to zero and a sticky interrupt request flag is raised.

Software reaches the timer through a small register port with a 2-bit address, 8-bit write data, a write strobe and combinational read data. The address map is: 0 = mode, 1 = modulo, 2 = counter (read-only), 3 = interrupt flag (bit 0). The system clock is never gated. A count pulse is a single-cycle enable, and all state changes happen on the rising clock edge.

Top module: `pitc_top`

## Requirements
- R1: After synchronous reset the mode, modulo and counter registers all read 0, and `irq` is 0.
- R2: With the run bit (mode bit 2) at 1, the count-pulse code in mode bits 6:4 sets the period between counter increments: code 100 gives 1024 clock cycles, 101 gives 256, 110 gives 64 and 111 gives 16. Pulses fall on the cycles where the low bits of the free-running prescaler (which reset clears) are all ones.
- R3: Codes 000 to 011 produce no count pulses, so the counter never changes while one of them is held.
- R4: Reading address 0 returns bits 6:4 and bit 2 as they were last written. Bits 7, 3, 1 and 0 always read 0, because the start command at bit 3 is not stored.
- R5: Writing address 0 with bit 3 at 1 clears the counter and the interrupt flag at that clock edge. This takes priority over a count pulse in the same cycle.
- R6: After a start command, counting proceeds only if bit 2 of that same written value is 1. Otherwise the counter stays at 0.
- R7: While the run bit is 0, the counter holds its value.
- R8: A count pulse that arrives while the counter equals the modulo value sets the counter to 0 and sets the interrupt flag. Otherwise a count pulse adds 1 to the counter, which wraps naturally at 8 bits.
- R9: The interrupt flag stays at 1 until a start command or a write to address 3 with bit 0 at 0. A write with bit 0 at 1 has no effect. If a clearing write and a flag-setting match fall in the same cycle, the flag ends at 1.
- R10: Reading the counter or modulo has no side effect. Writes to address 2 are ignored. Address 1 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one write per asserted cycle |
| rdData | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request flag |

## Verification
A wrong prescaler phase or tap choice shows up only as a counter value that is off by one against the modelled pulse schedule. That can take up to 1024 cycles to appear, so the checks sample the counter after windows several periods long for every code. A stuck or wrongly cleared flag shows on `irq` in the cycle after the match or the clearing write. A run bit or start command decoded at the wrong bit moves the counter within one pulse period.

// File: rtl/pitc_pkg.sv
`timescale 1ns/1ps
package pitc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_MODULO = 2'd1,
    REG_COUNT  = 2'd2,
    REG_FLAG   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic clrCnt;   // start command: clear counter and flag
    logic tick;     // one count pulse
    logic clrFlag;  // software clear of the flag
  } dpStrobe_t;
endpackage

// File: rtl/pitc_ctrl.sv
`timescale 1ns/1ps
module pitc_ctrl
  import pitc_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output dpStrobe_t           strb,
  output logic [DATA_W-1:0]   modeRd,
  output logic [CNT_W-1:0]    modulo
);
  localparam int NUM_TAPS = 4;

  logic [DIV_W-1:0]    divCnt;
  logic [2:0]          modeSel;
  logic                modeRun;
  logic [NUM_TAPS-1:0] tapHit;
  logic                modeWr, startCmd;

  assign modeWr   = wrEn && (addr == REG_MODE);
  assign startCmd = modeWr && wrData[3];

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else     divCnt <= divCnt + 1'b1;
  end

  // Tap i serves code 1ii: the divide ratio is 2^(DIV_W - 2*i)
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int SH = DIV_W - 2 * i;
    assign tapHit[i] = &divCnt[SH-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeSel <= '0;
      modeRun <= 1'b0;
      modulo  <= '0;
    end else if (wrEn) begin
      if (addr == REG_MODE) begin
        modeSel <= wrData[6:4];
        modeRun <= wrData[2];
      end
      if (addr == REG_MODULO) modulo <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.tick    = modeSel[2] && modeRun && tapHit[modeSel[1:0]];
    strb.clrCnt  = startCmd;
    strb.clrFlag = wrEn && (addr == REG_FLAG) && !wrData[0];
    modeRd       = {1'b0, modeSel, 1'b0, modeRun, 2'b00};
  end

  AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !modeRd[6] |-> !strb.tick);  // R3
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    strb.tick |=> !strb.tick);  // R2
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    !modeRd[2] |-> !strb.tick);  // R7
  AST_START_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    modeWr |=> (modeRd[3] == 1'b0) && (modeRd[1:0] == 2'b00));  // R4
endmodule

// File: rtl/pitc_dp.sv
`timescale 1ns/1ps
module pitc_dp
  import pitc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count,
  output logic             irqFlag
);
  logic wrap;
  assign wrap = strb.tick && (count == modulo);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strb.clrCnt) begin
      count <= '0;
    end else if (strb.tick) begin
      count <= wrap ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               irqFlag <= 1'b0;
    else if (strb.clrCnt)  irqFlag <= 1'b0;
    else if (wrap)         irqFlag <= 1'b1;
    else if (strb.clrFlag) irqFlag <= 1'b0;
  end

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    strb.tick && (count == modulo) && !strb.clrCnt |=> (count == '0) && irqFlag);  // R8
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
    !strb.tick && !strb.clrCnt |=> $stable(count));  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    irqFlag && !strb.clrCnt && !strb.clrFlag |=> irqFlag);  // R9
endmodule

// File: rtl/pitc_top.sv
`timescale 1ns/1ps
module pitc_top
  import pitc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  output logic [7:0] rdData,
  output logic       irq
);
  localparam int DIV_W = 10;
  localparam int CNT_W = 8;

  dpStrobe_t        strb;
  logic [7:0]       modeRd;
  logic [CNT_W-1:0] modulo;
  logic [CNT_W-1:0] count;

  pitc_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .modeRd(modeRd), .modulo(modulo)
  );

  pitc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .modulo(modulo),
    .count(count), .irqFlag(irq)
  );

  always_comb begin
    case (addr)
      REG_MODE:   rdData = modeRd;
      REG_MODULO: rdData = 8'(modulo);
      REG_COUNT:  rdData = 8'(count);
      default:    rdData = {7'd0, irq};
    endcase
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wrEn && (addr == REG_MODE) && wrData[3] |=> (count == '0) && !irq);  // R5
  AST_COUNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    wrEn && (addr == REG_COUNT) && !strb.tick |=> $stable(count));  // R10
endmodule

// File: tb/sim_pitc_top.sv
`timescale 1ns/100ps
module sim_pitc_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pitc_top u0 (.clk(clk), .rst(rst), .addr(addr), .wrData(wrData),
               .wrEn(wrEn), .rdData(rdData), .irq(irq));

  // Reference state built from the requirements
  int       mDiv;
  bit [2:0] mSel;
  bit       mRun;
  bit [7:0] mMod, mCnt;
  bit       mFlag;

  function automatic bit pulseDue(int dv, bit [2:0] sel, bit run);
    int sh, mask;
    sh = 10 - 2 * int'(sel[1:0]);
    mask = (1 << sh) - 1;
    return sel[2] && run && ((dv & mask) == mask);
  endfunction

  function automatic bit [7:0] expRead(int a);
    case (a)
      0: return {1'b0, mSel, 1'b0, mRun, 2'b00};
      1: return mMod;
      2: return mCnt;
      default: return {7'd0, mFlag};
    endcase
  endfunction

  always @(posedge clk) begin
    bit tk, st, wrp;
    if (rst) begin
      mDiv = 0; mSel = 0; mRun = 0; mMod = 0; mCnt = 0; mFlag = 0;
    end else begin
      tk  = pulseDue(mDiv, mSel, mRun);
      st  = wrEn && addr == 2'd0 && wrData[3];
      wrp = tk && (mCnt == mMod);
      if (st) begin
        mCnt = 0; mFlag = 0;
      end else begin
        if (tk) mCnt = wrp ? 8'd0 : mCnt + 8'd1;
        if (wrp) mFlag = 1;
        else if (wrEn && addr == 2'd3 && !wrData[0]) mFlag = 0;
      end
      if (wrEn && addr == 2'd0) begin mSel = wrData[6:4]; mRun = wrData[2]; end
      if (wrEn && addr == 2'd1) mMod = wrData;
      mDiv = (mDiv + 1) % 1024;
    end
  end

  task automatic checkAll(string tag);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #0.1;
      checks++;
      if (rdData !== expRead(a)) begin
        errors++;
        $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rdData, expRead(a));
      end
    end
    checks++;
    if (irq !== mFlag) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, mFlag);
    end
  endtask

  task automatic checkVal(string tag, int a, bit [7:0] want);
    addr = 2'(a);
    #0.1;
    checks++;
    if (rdData !== want) begin
      errors++;
      $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rdData, want);
    end
  endtask

  task automatic regWrite(int a, bit [7:0] d);
    @(negedge clk);
    addr = 2'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [7:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkAll("R1");
    checkVal("R1", 0, 8'h00);

    // R2: every legal code, several pulse periods each
    regWrite(1, 8'hFF);
    for (int c = 4; c < 8; c++) begin
      regWrite(0, 8'((c << 4) | 8'h0C));
      checkVal("R5", 2, 8'h00);
      idle(2 * (1 << (10 - 2 * (c - 4))) + 7);
      checkAll("R2");
    end

    // R3: prohibited codes never count
    for (int c = 0; c < 4; c++) begin
      regWrite(0, 8'((c << 4) | 8'h0C));
      idle(1100);
      checkVal("R3", 2, 8'h00);
      checkAll("R3");
    end

    // R4: readback hides bits 7,3,1,0
    regWrite(0, 8'hFB);
    checkVal("R4", 0, 8'h70);
    regWrite(0, 8'h04);
    checkVal("R4", 0, 8'h04);

    // R6: start with run bit 0 leaves counter at 0
    regWrite(0, 8'h74);
    idle(100);
    regWrite(0, 8'h78);
    idle(200);
    checkVal("R6", 2, 8'h00);
    checkAll("R6");

    // R7: stop holds the count
    regWrite(0, 8'h7C);
    idle(150);
    addr = 2'd2; #0.1; held = rdData;
    regWrite(0, 8'h70);
    addr = 2'd2; #0.1; held = rdData;
    idle(300);
    checkVal("R7", 2, held);
    checkAll("R7");

    // R8: small modulo, wrap and flag
    regWrite(1, 8'd3);
    regWrite(0, 8'h7C);
    idle(4 * 16 + 4);
    checkAll("R8");
    checkVal("R8", 3, 8'h01);

    // R9: sticky flag, write 1 no effect, write 0 clears
    regWrite(0, 8'h70);
    regWrite(3, 8'h01);
    checkVal("R9", 3, 8'h01);
    regWrite(3, 8'h00);
    checkVal("R9", 3, 8'h00);
    checkAll("R9");

    // R10: reads are side-effect free, counter writes ignored
    addr = 2'd2; #0.1; held = rdData;
    regWrite(2, 8'hA5);
    idle(5);
    checkVal("R10", 2, held);
    checkVal("R10", 1, 8'd3);
    checkAll("R10");

    // Random traffic against the reference state
    for (int it = 0; it < 400; it++) begin
      int a;
      bit [7:0] d;
      a = int'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 0 && $urandom_range(0, 3) != 0) d[6] = 1'b1;
      if (a == 1) d = 8'($urandom_range(0, 12));
      regWrite(a, d);
      idle(int'($urandom_range(0, 60)));
      checkAll("R8 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule